// File: doc/BRIEF.md
# Flash command sequencer

This block decodes the write cycles that a host issues to a parallel NOR-style flash device and turns them into array operations. Every write carries an address and a data word whose low byte is read as a command code. Some codes act at once. Others open a two-cycle sequence, and the following write either completes that sequence or is reported as a sequence error. The block starts word program, buffered program, block erase, one-time-programmable register program and a streaming factory-program mode. It also keeps per-block lock state, a read configuration word and a selector that chooses between array reads and status reads.

A parameterised down-counter stands in for the array algorithm. While it runs, the ready bit of the 8-bit status word is low and almost every command is dropped. A suspend command can freeze the counter for a program or an erase, and a resume command lets it continue from where it stopped. The array itself, the analog timing and the burst read path sit outside this block. The operation launch outputs are meant to drive that datapath.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, status reads 0x80 (bit 7 ready, all other bits 0), `rd_status` is 0 (array reads), `rcr` is 0, `bulk_mode` is 0 and `op_start` is 0.
- R2: Command 0x40 or 0x10 arms a word program. The next write launches it: one cycle after that write, `op_start` pulses with `op_kind`=1 and that write's address and data, `rd_status` becomes 1, and status bit 7 stays 0 for exactly PROG_CYC cycles.
- R3: Command 0x20 followed by 0xD0 launches a block erase (`op_kind`=3) at the address of the 0xD0 write. Status bit 7 is then 0 for exactly ERASE_CYC cycles.
- R4: A wrong second cycle sets status bits 5 and 4, selects status reads and launches nothing. This applies to anything other than 0xD0 after 0x20, 0x80 or a full buffered load, and to anything other than 0x01, 0xD0, 0x2F or 0x03 after 0x60.
- R5: While an operation runs, only 0x70 (select status reads) and 0xB0 (suspend) are acted on. Every other write leaves `rcr`, `rd_status`, the status word and the remaining busy time unchanged.
- R6: 0xB0 during a word program, buffered program or erase freezes the busy counter. It sets status bit 7, together with bit 2 for a program or bit 6 for an erase. A later 0xD0 clears that bit, drops bit 7 and runs out the remaining cycles.
- R7: While suspended, only 0xD0, 0x70 and 0xFF are acted on. Other commands, including setup codes, leave the status word and `rcr` unchanged.
- R8: Blocks are selected by the top log2(NUM_BLOCKS) address bits. After 0x60, 0x01 locks the block, 0xD0 unlocks it and 0x2F locks it down. An unlock has no effect on a locked-down block. A program to a locked block sets status bits 4 and 1, and an erase or buffered program to a locked block sets bits 5 and 1. In both cases nothing is launched.
- R9: 0x60 followed by 0x03 copies address bits [15:0] of the second write into `rcr` and selects array reads.
- R10: 0x50 clears status bits 5 to 1. 0x70 sets `rd_status` to 1 and 0xFF sets it to 0.
- R11: 0xC0 arms a protection register program. The next write launches `op_kind`=4 with its address and data for PROG_CYC busy cycles. This operation cannot be suspended.
- R12: 0xE8 starts a buffered program. The next write's data is the word count minus one, and a value of BUF_WORDS or more is a sequence error. That many data writes follow, then a 0xD0 confirm, which launches `op_kind`=2 with the 0xE8 address and the word count as data, for PROG_CYC plus the count busy cycles.
- R13: 0x80 followed by 0xD0 enters factory mode. In this mode `bulk_mode` is 1, status bit 7 is 0, and each write inside the latched block is passed on undecoded as `op_kind`=5. A write to another block leaves the mode, with status bit 7 going back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write cycle valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| status | output | 8 | Status word |
| rd_status | output | 1 | 1 selects status reads, 0 selects array reads |
| rcr | output | 16 | Read configuration word |
| op_start | output | 1 | One-cycle operation launch pulse |
| op_kind | output | 3 | Launched operation code |
| op_addr | output | ADDR_W | Launched operation address |
| op_data | output | DATA_W | Launched operation data or word count |
| bulk_mode | output | 1 | Factory streaming mode active |

## Verification
The hardest states to reach are a suspended erase that is fed setup codes before it resumes, and a running erase that is fed a complete configuration-register pair it must ignore. Both depend on exact cycle alignment against the busy counter. The bench drives writes on consecutive cycles from a known launch point, counts the cycles already spent, and then checks that the remaining busy time equals the configured duration minus the cycles spent before the freeze. A locked-down block that receives an unlock is only observable through a later failed program, so the bench follows every lock change with an operation on that block.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_WORD   = 3'd1,
      OP_BUFFER = 3'd2,
      OP_ERASE  = 3'd3,
      OP_OTP    = 3'd4,
      OP_BULK   = 3'd5
   } op_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG_SET,
      ST_ERASE_SET,
      ST_LOCK_SET,
      ST_OTP_SET,
      ST_BUF_CNT,
      ST_BUF_LOAD,
      ST_BUF_CONF,
      ST_BULK_SET,
      ST_BULK,
      ST_RUN,
      ST_SUSP
   } seq_state_e;

   localparam logic [7:0] C_PROG     = 8'h40;
   localparam logic [7:0] C_PROG_ALT = 8'h10;
   localparam logic [7:0] C_BUF      = 8'hE8;
   localparam logic [7:0] C_CONFIRM  = 8'hD0;
   localparam logic [7:0] C_BULK     = 8'h80;
   localparam logic [7:0] C_ERASE    = 8'h20;
   localparam logic [7:0] C_SUSPEND  = 8'hB0;
   localparam logic [7:0] C_LOCKSET  = 8'h60;
   localparam logic [7:0] C_LOCK     = 8'h01;
   localparam logic [7:0] C_LOCKDOWN = 8'h2F;
   localparam logic [7:0] C_RCR      = 8'h03;
   localparam logic [7:0] C_OTP      = 8'hC0;
   localparam logic [7:0] C_CLEAR    = 8'h50;
   localparam logic [7:0] C_RDSTAT   = 8'h70;
   localparam logic [7:0] C_RDARRAY  = 8'hFF;

endpackage

// File: rtl/flash_cmd_busy.sv
module flash_cmd_busy #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             hold,
   output logic             busy,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (!hold && cnt != '0) cnt <= cnt - CNT_W'(1);
   end

   assign busy = (cnt != '0);
   assign last = (cnt == CNT_W'(1));

   // R6: a frozen counter keeps its remaining time
   a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load) |=> $stable(cnt));

   // R2: a launch loads the full duration
   a_r2_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/flash_cmd_locks.sv
module flash_cmd_locks #(
   parameter int NUM_BLOCKS = 8,
   parameter int BLK_W      = 3,
   parameter bit LOCK_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_lock,
   input  logic             set_unlock,
   input  logic             set_down,
   input  logic [BLK_W-1:0] sel,
   input  logic [BLK_W-1:0] q_sel,
   output logic             q_locked
);
   if (LOCK_EN) begin : g_locks
      logic [NUM_BLOCKS-1:0] lk_vec;
      for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
         logic lk_b, dn_b, hit;
         assign hit = (sel == BLK_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lk_b <= 1'b0;
               dn_b <= 1'b0;
            end else if (hit) begin
               if (set_lock) lk_b <= 1'b1;
               if (set_down) begin
                  lk_b <= 1'b1;
                  dn_b <= 1'b1;
               end
               if (set_unlock && !dn_b) lk_b <= 1'b0;
            end
         end
         assign lk_vec[i] = lk_b;

         // R8: lock-down is permanent until reset
         a_r8_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
            dn_b |=> (lk_b && dn_b));
      end
      assign q_locked = lk_vec[q_sel];
   end else begin : g_nolocks
      logic unused_lock_inputs;
      assign unused_lock_inputs = ^{clk, rst_n, set_lock, set_unlock, set_down, sel, q_sel};
      assign q_locked = 1'b0;
   end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int NUM_BLOCKS = 8,
   parameter int BUF_WORDS  = 32,
   parameter int PROG_CYC   = 8,
   parameter int ERASE_CYC  = 24,
   parameter bit LOCK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [7:0]        status,
   output logic              rd_status,
   output logic [15:0]       rcr,
   output logic              op_start,
   output logic [2:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              bulk_mode
);
   localparam int BLK_W   = $clog2(NUM_BLOCKS);
   localparam int BUFC_W  = $clog2(BUF_WORDS + 1);
   localparam int BUF_MAX = PROG_CYC + BUF_WORDS;
   localparam int MAX_DUR = (ERASE_CYC > BUF_MAX) ? ERASE_CYC : BUF_MAX;
   localparam int CNT_W   = $clog2(MAX_DUR + 1);

   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two of at least 2");
   end
   if (ADDR_W < 16 || ADDR_W <= BLK_W) begin : g_bad_addr
      $error("ADDR_W must be at least 16 and wider than the block index");
   end
   if (DATA_W < 8 || BUF_WORDS < 1 || BUF_WORDS >= (1 << (DATA_W - 1))) begin : g_bad_data
      $error("DATA_W must hold a command byte and the buffer count");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_dur
      $error("busy durations must be at least one cycle");
   end

   seq_state_e        state, nxt_state;
   logic [6:0]        sr_q, nxt_sr;
   logic              rd_q, nxt_rd;
   logic [15:0]       rcr_q, nxt_rcr;
   op_kind_e          run_kind, nxt_kind;
   logic [BLK_W-1:0]  bulk_blk, nxt_bblk;
   logic [ADDR_W-1:0] setup_addr, nxt_saddr;
   logic [BUFC_W-1:0] buf_left, nxt_left, buf_total, nxt_total;

   logic              go;
   op_kind_e          go_kind;
   logic [ADDR_W-1:0] go_addr;
   logic [DATA_W-1:0] go_data;
   logic [CNT_W-1:0]  go_dur;
   logic              lk_set, lk_clr, lk_down, q_locked;
   logic              bz_busy, bz_last;
   logic [BLK_W-1:0]  q_blk;

   logic              op_start_q;
   op_kind_e          op_kind_q;
   logic [ADDR_W-1:0] op_addr_q;
   logic [DATA_W-1:0] op_data_q;

   wire [7:0]       cmd  = wr_data[7:0];
   wire [BLK_W-1:0] wblk = wr_addr[ADDR_W-1 -: BLK_W];

   always_comb begin
      if (state == ST_BUF_CONF)       q_blk = setup_addr[ADDR_W-1 -: BLK_W];
      else if (state == ST_BULK_SET)  q_blk = bulk_blk;
      else                            q_blk = wblk;
   end

   flash_cmd_locks #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .LOCK_EN(LOCK_EN)) u_locks (
      .clk, .rst_n,
      .set_lock(lk_set), .set_unlock(lk_clr), .set_down(lk_down),
      .sel(wblk), .q_sel(q_blk), .q_locked(q_locked)
   );

   flash_cmd_busy #(.CNT_W(CNT_W)) u_busy (
      .clk, .rst_n,
      .load(go && go_kind != OP_BULK), .load_val(go_dur),
      .hold(state == ST_SUSP), .busy(bz_busy), .last(bz_last)
   );

   always_comb begin
      nxt_state = state;      nxt_sr    = sr_q;     nxt_rd   = rd_q;
      nxt_rcr   = rcr_q;      nxt_kind  = run_kind; nxt_bblk = bulk_blk;
      nxt_saddr = setup_addr; nxt_left  = buf_left; nxt_total = buf_total;
      go = 1'b0; go_kind = OP_NONE; go_addr = wr_addr; go_data = wr_data; go_dur = '0;
      lk_set = 1'b0; lk_clr = 1'b0; lk_down = 1'b0;
      unique case (state)
         ST_IDLE: if (wr_en) begin
            unique case (cmd)
               C_PROG, C_PROG_ALT: nxt_state = ST_PROG_SET;
               C_ERASE:   nxt_state = ST_ERASE_SET;
               C_LOCKSET: nxt_state = ST_LOCK_SET;
               C_OTP:     nxt_state = ST_OTP_SET;
               C_BUF: begin nxt_state = ST_BUF_CNT; nxt_saddr = wr_addr; end
               C_BULK: begin nxt_state = ST_BULK_SET; nxt_bblk = wblk; end
               C_CLEAR:   nxt_sr[5:1] = '0;
               C_RDSTAT:  nxt_rd = 1'b1;
               C_RDARRAY: nxt_rd = 1'b0;
               default: ;
            endcase
         end
         ST_PROG_SET: if (wr_en) begin
            nxt_rd = 1'b1;
            nxt_state = ST_IDLE;
            if (q_locked) begin
               nxt_sr[4] = 1'b1; nxt_sr[1] = 1'b1;
            end else begin
               go = 1'b1; go_kind = OP_WORD; go_dur = CNT_W'(PROG_CYC);
               nxt_state = ST_RUN;
            end
         end
         ST_ERASE_SET: if (wr_en) begin
            nxt_rd = 1'b1;
            nxt_state = ST_IDLE;
            if (cmd != C_CONFIRM) begin
               nxt_sr[5] = 1'b1; nxt_sr[4] = 1'b1;
            end else if (q_locked) begin
               nxt_sr[5] = 1'b1; nxt_sr[1] = 1'b1;
            end else begin
               go = 1'b1; go_kind = OP_ERASE; go_dur = CNT_W'(ERASE_CYC);
               nxt_state = ST_RUN;
            end
         end
         ST_LOCK_SET: if (wr_en) begin
            nxt_state = ST_IDLE;
            unique case (cmd)
               C_LOCK:     lk_set  = 1'b1;
               C_CONFIRM:  lk_clr  = 1'b1;
               C_LOCKDOWN: lk_down = 1'b1;
               C_RCR: begin nxt_rcr = wr_addr[15:0]; nxt_rd = 1'b0; end
               default: begin
                  nxt_sr[5] = 1'b1; nxt_sr[4] = 1'b1; nxt_rd = 1'b1;
               end
            endcase
         end
         ST_OTP_SET: if (wr_en) begin
            nxt_rd = 1'b1;
            go = 1'b1; go_kind = OP_OTP; go_dur = CNT_W'(PROG_CYC);
            nxt_state = ST_RUN;
         end
         ST_BUF_CNT: if (wr_en) begin
            nxt_rd = 1'b1;
            if (wr_data >= DATA_W'(BUF_WORDS)) begin
               nxt_sr[5] = 1'b1; nxt_sr[4] = 1'b1;
               nxt_state = ST_IDLE;
            end else begin
               nxt_left  = BUFC_W'(wr_data) + BUFC_W'(1);
               nxt_total = BUFC_W'(wr_data) + BUFC_W'(1);
               nxt_state = ST_BUF_LOAD;
            end
         end
         ST_BUF_LOAD: if (wr_en) begin
            nxt_left = buf_left - BUFC_W'(1);
            if (buf_left == BUFC_W'(1)) nxt_state = ST_BUF_CONF;
         end
         ST_BUF_CONF: if (wr_en) begin
            nxt_rd = 1'b1;
            nxt_state = ST_IDLE;
            if (cmd != C_CONFIRM) begin
               nxt_sr[5] = 1'b1; nxt_sr[4] = 1'b1;
            end else if (q_locked) begin
               nxt_sr[5] = 1'b1; nxt_sr[1] = 1'b1;
            end else begin
               go = 1'b1; go_kind = OP_BUFFER;
               go_addr = setup_addr; go_data = DATA_W'(buf_total);
               go_dur = CNT_W'(PROG_CYC) + CNT_W'(buf_total);
               nxt_state = ST_RUN;
            end
         end
         ST_BULK_SET: if (wr_en) begin
            nxt_rd = 1'b1;
            nxt_state = ST_IDLE;
            if (cmd != C_CONFIRM) begin
               nxt_sr[5] = 1'b1; nxt_sr[4] = 1'b1;
            end else if (q_locked) begin
               nxt_sr[4] = 1'b1; nxt_sr[1] = 1'b1;
            end else begin
               nxt_state = ST_BULK;
            end
         end
         ST_BULK: if (wr_en) begin
            if (wblk == bulk_blk) begin
               go = 1'b1; go_kind = OP_BULK;
            end else begin
               nxt_state = ST_IDLE;
               nxt_rd = 1'b1;
            end
         end
         ST_RUN: begin
            if (bz_last) begin
               nxt_state = ST_IDLE;
            end else if (wr_en) begin
               if (cmd == C_RDSTAT) nxt_rd = 1'b1;
               if (cmd == C_SUSPEND && run_kind != OP_OTP) begin
                  nxt_state = ST_SUSP;
                  nxt_rd = 1'b1;
                  if (run_kind == OP_ERASE) nxt_sr[6] = 1'b1;
                  else                      nxt_sr[2] = 1'b1;
               end
            end
         end
         ST_SUSP: if (wr_en) begin
            unique case (cmd)
               C_CONFIRM: begin
                  nxt_state = ST_RUN;
                  nxt_sr[6] = 1'b0; nxt_sr[2] = 1'b0;
               end
               C_RDSTAT:  nxt_rd = 1'b1;
               C_RDARRAY: nxt_rd = 1'b0;
               default: ;
            endcase
         end
         default: nxt_state = ST_IDLE;
      endcase
      if (go) nxt_kind = go_kind;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;   sr_q <= '0;        rd_q <= 1'b0;
         rcr_q <= '0;        run_kind <= OP_NONE; bulk_blk <= '0;
         setup_addr <= '0;   buf_left <= '0;    buf_total <= '0;
         op_start_q <= 1'b0; op_kind_q <= OP_NONE;
         op_addr_q <= '0;    op_data_q <= '0;
      end else begin
         state <= nxt_state; sr_q <= nxt_sr;     rd_q <= nxt_rd;
         rcr_q <= nxt_rcr;   run_kind <= nxt_kind; bulk_blk <= nxt_bblk;
         setup_addr <= nxt_saddr; buf_left <= nxt_left; buf_total <= nxt_total;
         op_start_q <= go;
         if (go) begin
            op_kind_q <= go_kind;
            op_addr_q <= go_addr;
            op_data_q <= go_data;
         end
      end
   end

   assign status    = {!((state == ST_RUN) || (state == ST_BULK)), sr_q};
   assign rd_status = rd_q;
   assign rcr       = rcr_q;
   assign op_start  = op_start_q;
   assign op_kind   = op_kind_q;
   assign op_addr   = op_addr_q;
   assign op_data   = op_data_q;
   assign bulk_mode = (state == ST_BULK);

   // R4: wrong erase confirm flags a sequence error
   a_r4_erase_seq_err: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE_SET && wr_en && cmd != C_CONFIRM)
         |=> (status[5] && status[4] && rd_status && !op_start));

   // R5: dropped commands during a run touch nothing visible
   a_r5_run_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !bz_last && wr_en && cmd != C_RDSTAT && cmd != C_SUSPEND)
         |=> ($stable(rcr) && $stable(rd_status) && !op_start));

   // R6: erase suspend reports ready and erase-suspended
   a_r6_erase_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !bz_last && wr_en && cmd == C_SUSPEND && run_kind == OP_ERASE)
         |=> (status[7] && status[6]));

   // R3: a launched run keeps the counter active
   a_r3_run_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> bz_busy);

   // R13: writes inside the factory block are forwarded
   a_r13_bulk_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BULK && wr_en && wblk == bulk_blk)
         |=> (op_start && op_kind == 3'd5));
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
   localparam int AW = 16, DW = 16, NB = 8, BW = 32, PC = 8, EC = 24;

   logic          clk = 1'b0;
   logic          rst_n, wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [7:0]    status;
   logic          rd_status, op_start, bulk_mode;
   logic [15:0]   rcr;
   logic [2:0]    op_kind;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_BLOCKS(NB), .BUF_WORDS(BW),
                   .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_EN(1'b1)) dut (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .status, .rd_status, .rcr,
      .op_start, .op_kind, .op_addr, .op_data, .bulk_mode
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_ready(input string req, input int exp);
      int n = 0;
      while (status[7] == 1'b0 && n < 1000) begin
         n++;
         @(negedge clk);
      end
      check(req, "busy cycles", n, exp);
   endtask

   task automatic t_reset;
      check("R1", "status", status, 8'h80);
      check("R1", "rd_status", rd_status, 0);
      check("R1", "rcr", rcr, 0);
      check("R1", "bulk_mode", bulk_mode, 0);
      check("R1", "op_start", op_start, 0);
   endtask

   task automatic t_word;
      wr(16'h1234, 16'h0040);
      wr(16'h1236, 16'hBEEF);
      check("R2", "op_start", op_start, 1);
      check("R2", "op_kind", op_kind, 1);
      check("R2", "op_addr", op_addr, 16'h1236);
      check("R2", "op_data", op_data, 16'hBEEF);
      check("R2", "rd_status", rd_status, 1);
      wait_ready("R2", PC);
      check("R2", "status after", status, 8'h80);
      wr(16'h0000, 16'h0010);
      wr(16'h0040, 16'h5A5A);
      check("R2", "alt op_kind", op_kind, 1);
      check("R2", "alt op_data", op_data, 16'h5A5A);
      wait_ready("R2", PC);
   endtask

   task automatic t_erase;
      wr(16'h4000, 16'h0020);
      wr(16'h4100, 16'h00D0);
      check("R3", "op_start", op_start, 1);
      check("R3", "op_kind", op_kind, 3);
      check("R3", "op_addr", op_addr, 16'h4100);
      wait_ready("R3", EC);
   endtask

   task automatic t_seq_and_modes;
      wr(16'h4000, 16'h0020);
      wr(16'h4000, 16'h00FF);
      check("R4", "erase seq err status", status, 8'hB0);
      check("R4", "rd_status", rd_status, 1);
      check("R4", "no launch", op_start, 0);
      wr(16'h0000, 16'h0050);
      check("R10", "clear", status, 8'h80);
      wr(16'h0000, 16'h0060);
      wr(16'h0000, 16'h0077);
      check("R4", "lock setup seq err", status, 8'hB0);
      wr(16'h0000, 16'h0050);
      wr(16'h0000, 16'h0080);
      wr(16'h8000, 16'h0040);
      check("R4", "factory setup seq err", status, 8'hB0);
      check("R4", "factory not entered", bulk_mode, 0);
      wr(16'h0000, 16'h0050);
      wr(16'h0000, 16'h00FF);
      check("R10", "read array", rd_status, 0);
      wr(16'h0000, 16'h0070);
      check("R10", "read status", rd_status, 1);
   endtask

   task automatic t_ignore;
      wr(16'h0000, 16'h00FF);
      wr(16'h4000, 16'h0020);
      wr(16'h4000, 16'h00D0);
      wr(16'h0000, 16'h00FF);
      check("R5", "read array dropped", rd_status, 1);
      wr(16'h5555, 16'h0060);
      wr(16'h5555, 16'h0003);
      check("R5", "rcr unchanged", rcr, 0);
      check("R5", "no launch", op_start, 0);
      wait_ready("R5", EC - 3);
      check("R5", "status clean", status, 8'h80);
   endtask

   task automatic t_suspend;
      wr(16'h4000, 16'h0020);
      wr(16'h4000, 16'h00D0);
      idle(4);
      wr(16'h0000, 16'h00B0);
      check("R6", "erase suspended", status, 8'hC0);
      idle(10);
      wr(16'h0000, 16'h0020);
      wr(16'h7777, 16'h0060);
      wr(16'h7777, 16'h0003);
      check("R7", "status held", status, 8'hC0);
      check("R7", "rcr unchanged", rcr, 0);
      wr(16'h0000, 16'h00D0);
      check("R6", "resumed", status, 8'h00);
      wait_ready("R6", EC - 5);
      wr(16'h0100, 16'h0040);
      wr(16'h0102, 16'h1111);
      wr(16'h0000, 16'h00B0);
      check("R6", "program suspended", status, 8'h84);
      wr(16'h0000, 16'h00D0);
      wait_ready("R6", PC - 1);
   endtask

   task automatic t_otp;
      wr(16'h0010, 16'h00C0);
      wr(16'h0012, 16'hA5A5);
      check("R11", "op_kind", op_kind, 4);
      check("R11", "op_addr", op_addr, 16'h0012);
      check("R11", "op_data", op_data, 16'hA5A5);
      wr(16'h0000, 16'h00B0);
      check("R11", "not suspended", status, 8'h00);
      wait_ready("R11", PC - 1);
   endtask

   task automatic t_lock;
      wr(16'h6000, 16'h0060);
      wr(16'h6000, 16'h0001);
      wr(16'h6000, 16'h0040);
      wr(16'h6002, 16'h1234);
      check("R8", "program to locked", status, 8'h92);
      check("R8", "no launch", op_start, 0);
      wr(16'h0000, 16'h0050);
      wr(16'h6000, 16'h0020);
      wr(16'h6000, 16'h00D0);
      check("R8", "erase to locked", status, 8'hA2);
      wr(16'h0000, 16'h0050);
      wr(16'h6000, 16'h0060);
      wr(16'h6000, 16'h00D0);
      wr(16'h6000, 16'h0020);
      wr(16'h6000, 16'h00D0);
      check("R8", "erase after unlock", op_kind, 3);
      wait_ready("R8", EC);
      wr(16'h6000, 16'h0060);
      wr(16'h6000, 16'h002F);
      wr(16'h6000, 16'h0060);
      wr(16'h6000, 16'h00D0);
      wr(16'h6000, 16'h0040);
      wr(16'h6004, 16'h4321);
      check("R8", "unlock of locked-down ignored", status, 8'h92);
      wr(16'h0000, 16'h0050);
   endtask

   task automatic t_rcr;
      wr(16'hABCD, 16'h0060);
      wr(16'h1357, 16'h0003);
      check("R9", "rcr", rcr, 16'h1357);
      check("R9", "array mode", rd_status, 0);
      check("R9", "status", status, 8'h80);
   endtask

   task automatic t_buffer;
      wr(16'h2000, 16'h00E8);
      wr(16'h2000, 16'h0003);
      wr(16'h2000, 16'h00D0);
      wr(16'h2002, 16'h0020);
      wr(16'h2004, 16'h0060);
      wr(16'h2006, 16'h9999);
      wr(16'h2000, 16'h00D0);
      check("R12", "op_kind", op_kind, 2);
      check("R12", "op_addr", op_addr, 16'h2000);
      check("R12", "op_data", op_data, 4);
      wait_ready("R12", PC + 4);
      wr(16'h2000, 16'h00E8);
      wr(16'h2000, 16'(BW));
      check("R12", "count overflow", status, 8'hB0);
      wr(16'h0000, 16'h0050);
   endtask

   task automatic t_bulk;
      wr(16'h8000, 16'h0080);
      wr(16'h8000, 16'h00D0);
      check("R13", "bulk_mode", bulk_mode, 1);
      check("R13", "ready low", status[7], 0);
      wr(16'h8002, 16'h0070);
      check("R13", "op_kind", op_kind, 5);
      check("R13", "op_addr", op_addr, 16'h8002);
      check("R13", "op_data", op_data, 16'h0070);
      wr(16'hA000, 16'hFFFF);
      check("R13", "exit", bulk_mode, 0);
      check("R13", "status after exit", status, 8'h80);
      check("R13", "no launch on exit", op_start, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word();
      t_erase();
      t_seq_and_modes();
      t_ignore();
      t_suspend();
      t_otp();
      t_lock();
      t_rcr();
      t_buffer();
      t_bulk();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule